// File: doc/BRIEF.md
# Clock-Sampled Programmable Delay with Pulse Mode

This block is a synchronous model of a programmable timing element. A one-bit input is sampled on every clock. An 8-bit setting selects how many extra cycles that input is held back before it reaches the outputs. Internally, the samples shift through a history register of 258 stages. A tap chosen by the setting feeds the delayed output. Because the whole history is kept, every transition inside the delay window comes out again, even when the delay is longer than the input's high or low time.

A mode bit gives the two outputs their roles. In normal mode, `out_a` is a reference copy of the input at a fixed 3-cycle delay. In the same mode, `out_b` is a copy of the input, with the same polarity, delayed by 2 cycles plus the setting. A setting of zero therefore makes `out_b` lead the reference by exactly one cycle. In pulse mode, `out_b` becomes the inverted delayed copy and `out_a` carries a one-shot pulse. The one-shot fires on a sampled rising edge of the input. Its output goes high 2 cycles after that edge and stays high for as many cycles as the active setting. It cannot be retriggered while it is high, and a setting of zero produces no pulse.

The setting and mode inputs are registered: a value applied before a clock edge governs the outputs from that edge on. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `prog_timing_elem`

## Requirements
- R1: While reset is asserted, both outputs are 0, the history is cleared, the one-shot is idle and the registered mode is normal.
- R2: The mode bit is registered; in normal mode (mode bit 0), after clock edge k, `out_b` equals the input sampled at edge k-(2+S), where S is the setting sampled at edge k.
- R3: With a setting of 0 in normal mode, `out_b` shows each sample exactly one cycle before `out_a` shows it.
- R4: In normal mode, after edge k, `out_a` equals the input sampled at edge k-3, whatever the setting.
- R5: In pulse mode (mode bit 1), after edge k, `out_b` equals the inverse of the input sampled at edge k-(2+S).
- R6: In pulse mode, a rising edge first seen at sample j (sample j is 1 and sample j-1 is 0) makes `out_a` high after edges j+2 through j+1+W. W is the setting value that was active before edge j+2, that is, the setting sampled at edge j+1.
- R7: A rising edge whose trigger edge j+2 falls while the pulse is high (the pulse was high before that edge) is ignored and neither extends nor restarts the pulse.
- R8: A pulse width W of 0 produces no pulse; `out_a` stays low in pulse mode.
- R9: With the delay longer than the input's high and low times, every transition of the input reappears on `out_b` with the programmed delay.
- R10: A new setting applied before edge k selects the `out_b` tap from edge k on, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| sig_in | input | 1 | Input signal, sampled each clock |
| setting | input | 8 | Programmed delay (both modes) and pulse width (pulse mode), in cycles |
| mode_sel | input | 1 | 0: reference and delayed copy; 1: pulse and inverted delayed copy |
| out_a | output | 1 | Reference copy (mode 0) or one-shot pulse (mode 1) |
| out_b | output | 1 | Delayed copy (mode 0) or inverted delayed copy (mode 1) |

## Verification
Several properties are checked on every cycle. In normal mode, the reference output matches the input from four sampled cycles earlier. With a zero setting, the reference trails the delayed output by one cycle. The one-shot only starts after a trigger with a nonzero width. A zero width keeps it idle, and a trigger that arrives during a pulse does not disturb the countdown. Only the bench scenarios can show the long-window behaviour: taps deep in the history, including the full 257-cycle delay, and several transitions in flight at once. The same holds for setting changes mid-stream, pulse start and length against the input, and the interplay of overlapping rising edges with the non-retriggerable pulse.

// File: rtl/pte_pkg.sv
package pte_pkg;
  parameter int SET_W    = 8;
  parameter int BASE_DLY = 2;
  parameter int REF_DLY  = 3;
  localparam int HIST_DEPTH = BASE_DLY + (1 << SET_W);

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_PULSE  = 1'b1
  } mode_e;
endpackage

// File: rtl/pte_rst_sync.sv
module pte_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pte_history.sv
module pte_history #(
  parameter int DEPTH = pte_pkg::HIST_DEPTH,
  parameter int SET_W = pte_pkg::SET_W,
  parameter int BASE  = pte_pkg::BASE_DLY,
  parameter int REFD  = pte_pkg::REF_DLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SET_W-1:0] sel,
  output logic             tap_o,
  output logic             ref_o,
  output logic             rise_o
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] hist;
  logic [DEPTH-1:0] hist_d;
  logic [IW-1:0]    tap_idx;

  // Stage 0 takes the new sample, each later stage takes its predecessor.
  assign hist_d[0] = din;
  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    assign hist_d[g] = hist[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= hist_d;
  end

  // Before edge e, hist[i] holds the sample from edge e-1-i.
  assign tap_idx = IW'(BASE) + IW'(sel);
  assign tap_o   = hist[tap_idx];
  assign ref_o   = hist[REFD];
  // Rising sample seen two edges back, so the pulse starts BASE cycles later.
  assign rise_o  = hist[BASE-1] & ~hist[BASE];
endmodule

// File: rtl/pte_oneshot.sv
module pte_oneshot #(
  parameter int SET_W = pte_pkg::SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [SET_W-1:0] width_i,
  output logic             pulse_o
);
  logic             act_q, act_d;
  logic [SET_W-1:0] rem_q, rem_d;

  always_comb begin
    act_d = act_q;
    rem_d = rem_q;
    if (act_q) begin
      if (rem_q == SET_W'(1)) begin
        act_d = 1'b0;
        rem_d = '0;
      end else begin
        rem_d = rem_q - SET_W'(1);
      end
    end else if (trig_i && (width_i != '0)) begin
      act_d = 1'b1;
      rem_d = width_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else begin
      act_q <= act_d;
      rem_q <= rem_d;
    end
  end

  assign pulse_o = act_q;

  assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(trig_i) && ($past(width_i) != '0)));

  assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && (width_i == '0)) |=> !act_q);

  assert_no_retrig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && trig_i) |=> (!act_q || (rem_q == $past(rem_q) - SET_W'(1))));
endmodule

// File: rtl/prog_timing_elem.sv
module prog_timing_elem #(
  parameter int SET_W = pte_pkg::SET_W,
  parameter int BASE  = pte_pkg::BASE_DLY,
  parameter int REFD  = pte_pkg::REF_DLY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [SET_W-1:0] setting,
  input  logic             mode_sel,
  output logic             out_a,
  output logic             out_b
);
  import pte_pkg::*;

  localparam int DEPTH = BASE + (1 << SET_W);

  logic             srst_n;
  logic [SET_W-1:0] set_q, set_d;
  mode_e            mode_q, mode_d;
  logic             tap, ref_tap, rise, pulse;
  logic [2:0]       up_cnt;

  pte_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    set_d  = setting;
    mode_d = mode_e'(mode_sel);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      set_q  <= '0;
      mode_q <= MODE_NORMAL;
    end else begin
      set_q  <= set_d;
      mode_q <= mode_d;
    end
  end

  pte_history #(
    .DEPTH (DEPTH),
    .SET_W (SET_W),
    .BASE  (BASE),
    .REFD  (REFD)
  ) u_hist (
    .clk    (clk),
    .rst_n  (srst_n),
    .din    (sig_in),
    .sel    (set_q),
    .tap_o  (tap),
    .ref_o  (ref_tap),
    .rise_o (rise)
  );

  pte_oneshot #(.SET_W(SET_W)) u_shot (
    .clk     (clk),
    .rst_n   (srst_n),
    .trig_i  (rise),
    .width_i (set_q),
    .pulse_o (pulse)
  );

  always_comb begin
    if (mode_q == MODE_PULSE) begin
      out_a = pulse;
      out_b = ~tap;
    end else begin
      out_a = ref_tap;
      out_b = tap;
    end
  end

  // Cycles since reset release, used only to gate history-based checks.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)            up_cnt <= '0;
    else if (up_cnt != 3'd7) up_cnt <= up_cnt + 3'd1;
  end

  assert_ref_delay_R4: assert property (@(posedge clk) disable iff (!srst_n)
    ((up_cnt >= 3'd5) && (mode_q == MODE_NORMAL)) |-> (out_a == $past(sig_in, REFD + 1)));

  assert_ref_lag_R3: assert property (@(posedge clk) disable iff (!srst_n)
    ((up_cnt >= 3'd5) && (mode_q == MODE_NORMAL) && ($past(mode_q) == MODE_NORMAL)
     && (set_q == '0) && ($past(set_q) == '0)) |-> (out_a == $past(out_b)));
endmodule

// File: tb/tb_prog_timing_elem.sv
module tb_prog_timing_elem;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sig_in;
  logic [7:0] setting;
  logic       mode_sel;
  logic       out_a, out_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  a;
    logic  b;
    string tag_a;
    string tag_b;
  } exp_t;

  exp_t exp_q[$];

  bit       samp [0:4095];
  bit [7:0] setv [0:4095];
  int       n = 0;
  bit       ph_prev = 1'b0;
  int       p_en = -1;

  always #2.5 clk = ~clk;

  prog_timing_elem dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_in   (sig_in),
    .setting  (setting),
    .mode_sel (mode_sel),
    .out_a    (out_a),
    .out_b    (out_b)
  );

  function automatic bit smp(int i);
    return (i < 0) ? 1'b0 : samp[i];
  endfunction

  function automatic bit [7:0] stv(int i);
    return (i < 0) ? 8'd0 : setv[i];
  endfunction

  task automatic check(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b step=%0d", tag, act, expv, n);
    end
  endtask

  // Driver: apply inputs for edge n and push the outputs expected after it.
  task automatic step(bit in, bit [7:0] s, bit md, string ta, string tb);
    exp_t e;
    bit dly, rise, ph;
    int w;
    @(negedge clk);
    sig_in   = in;
    setting  = s;
    mode_sel = md;
    samp[n]  = in;
    setv[n]  = s;
    dly  = smp(n - 2 - int'(s));
    rise = smp(n - 2) && !smp(n - 3);
    w    = int'(stv(n - 1));
    if (ph_prev) ph = (n <= p_en);
    else if (rise && (w != 0)) begin
      ph   = 1'b1;
      p_en = n + w - 1;
    end else ph = 1'b0;
    ph_prev = ph;
    e.a = md ? ph : smp(n - 3);
    e.b = md ? ~dly : dly;
    e.tag_a = ta;
    e.tag_b = tb;
    exp_q.push_back(e);
    n++;
  endtask

  // Monitor: compare one expectation per edge, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag_a, out_a, e.a);
      check(e.tag_b, out_b, e.b);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sig_in = 1'b1; setting = 8'd7; mode_sel = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held low while reset is asserted, mode forced normal
    check("R1 out_a", out_a, 1'b0);
    check("R1 out_b", out_b, 1'b0);
    sig_in = 1'b0; setting = 8'd0; mode_sel = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R3: setting zero, irregular pattern, out_b leads reference by one
    for (int i = 0; i < 60; i++) step(((i * 7) % 5) < 2, 8'd0, 1'b0, "R4", "R3");
    // R2: setting 5
    for (int i = 0; i < 60; i++) step(((i / 3) % 2) == 1, 8'd5, 1'b0, "R4", "R2");
    // R9: delay of 42 with input toggling every 3 cycles
    for (int i = 0; i < 120; i++) step(((i / 3) % 2) == 1, 8'd40, 1'b0, "R4", "R9");
    // R2: maximum setting, full depth of the history
    for (int i = 0; i < 320; i++) step((i % 11) < 4, 8'd255, 1'b0, "R4", "R2");
    // R10: setting changes mid-stream
    for (int i = 0; i < 90; i++)
      step(((i / 2) % 3) == 0, (i < 30) ? 8'd3 : ((i < 60) ? 8'd9 : 8'd1), 1'b0, "R4", "R10");
    // R6: isolated rising edges, width 4
    for (int i = 0; i < 60; i++) step((i % 15) < 2, 8'd4, 1'b1, "R6", "R5");
    // R7: rises every 4 cycles, width 10, later rises ignored
    for (int i = 0; i < 80; i++) step((i % 4) == 0, 8'd10, 1'b1, "R7", "R5");
    // R8: width zero, no pulse
    for (int i = 0; i < 60; i++) step((i % 6) < 3, 8'd0, 1'b1, "R8", "R5");
    // R6: width 1 and width 255 via a long gap
    for (int i = 0; i < 40; i++) step((i % 8) == 2, 8'd1, 1'b1, "R6", "R5");
    for (int i = 0; i < 300; i++) step(i == 5, 8'd255, 1'b1, "R6", "R5");

    @(negedge clk);
    sig_in = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule